// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command state machine behind the write side of a multi-bank NOR flash. It watches host write cycles (address, data and a one-cycle write enable). It picks out command sequences that start with a two-write unlock prefix and acts on them. The commands are: autoselect entry for a bank, entry to and exit from a secured data region, single-location program, and reset. For each bank it reports a two-bit mode. It also drives a select line that steers reads into the secured region.

A program command starts a modelled embedded program operation. The ready output goes low for a fixed number of cycles, and the latched target address and data are presented on outputs. The operation then completes and the bank returns to its resting mode. If the modelled cell fails to verify at the end of the operation, a timeout flag is raised and the operation stays pending until a reset command clears it. An erase engine outside this block reports two per-bank inputs: which banks are erasing and which are in erase suspend. Commands are accepted or refused using these inputs together with the program-busy state and the secured-region state.

Top module: `flash_cmd_seq`

## Requirements
- R1: A command begins with a write of data 0xAA to an address whose low 11 bits are 0x555, followed by a write of 0x55 to low address 0x2AA. The third write must go to low address 0x555 and carries the command byte in data bits 7:0: 0x90 autoselect, 0x88 secured-region entry, 0xA0 program set-up.
- R2: An autoselect command selects the bank given by the top log2(NUM_BANKS) address bits of its third write. That bank's mode becomes 2'b01 and stays there through any number of cycles and unrelated writes until a reset command. Mode encoding: 2'b00 read, 2'b01 autoselect, 2'b10 erase-suspend-read, 2'b11 programming.
- R3: An autoselect command is refused, leaving all modes unchanged, if any bank is erasing.
- R4: A reset command is a single write with data 0xF0 at any address, outside the program-data and exit-data positions. It returns every autoselect bank to read mode, or to erase-suspend-read mode where that bank's suspend input is high.
- R5: A program sequence is the unlock prefix, 0xA0, then one write of target address and data. ready falls after that write. The target bank shows mode 2'b11, and progAddr/progData hold the written address and data. After exactly PROG_LAT cycles ready rises, the bank returns to its resting mode, and progAddr/progData return to zero.
- R6: While a program operation is running, every write is ignored, including secured-entry and reset commands, and the operation length is unchanged.
- R7: Asserting rst_n low aborts a running program operation at once: ready is high and all modes are read.
- R8: Secured-region entry (unlock, 0x88) sets secSel. It is refused while a program operation is running or any bank is erasing.
- R9: While secSel is high, the sequence unlock, 0x90, then a write of data 0x00 clears secSel. In this state 0x90 changes no bank mode, and any other final data leaves secSel high.
- R10: If verifyFail is high in the final cycle of a program operation, timeoutFlag rises, ready stays low and the bank stays in mode 2'b11. Only a 0xF0 write then clears the flag, raises ready and returns the bank to read, or to erase-suspend-read if it is suspended.
- R11: A write with the wrong address or data at any step of a sequence returns the decoder to idle without changing any mode or secSel. A fresh unlock prefix then works.
- R12: The final program write is refused, and no operation starts, if the target bank is erasing or in autoselect mode.
- R13: After reset, ready is high, secSel and timeoutFlag are low, every bank mode is read, and progAddr/progData are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wrEn | input | 1 | Host write strobe, one cycle per write |
| addr | input | ADDR_W | Write address; top bits select the bank |
| wrData | input | DATA_W | Write data; bits 7:0 carry command bytes |
| eraseActive | input | NUM_BANKS | Per-bank erase-in-progress indication |
| eraseSuspended | input | NUM_BANKS | Per-bank erase-suspend indication |
| verifyFail | input | 1 | Modelled cell verify failure, sampled at program end |
| bankMode | output | 2*NUM_BANKS | Two-bit mode per bank, bank b at bits 2b+1:2b |
| secSel | output | 1 | Reads steered to the secured region |
| ready | output | 1 | High when no program operation is pending |
| timeoutFlag | output | 1 | Program operation timed out |
| progAddr | output | ADDR_W | Latched program address, zero when idle |
| progData | output | DATA_W | Latched program data, zero when idle |

## Verification
Autoselect is driven to different banks with the erase-suspend input both low and high. This separates a reset that always goes to read mode from one that remembers suspension. Broken prefixes at each of the three positions show whether a stray write can leak into a mode change. Bursts of command writes during a program operation show whether busy really blocks writes or only delays them. Program is run to a clean finish, to a verify timeout and into a hardware reset, which separates the three ways an operation can end. The secured region is entered and exited with the right and wrong final data, and with an erase in progress, to show that 0x90 is routed by secured state and not by the autoselect path.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

  localparam int LOW_ADDR_W = 11;

  localparam logic [LOW_ADDR_W-1:0] ADR_FIRST  = 11'h555;
  localparam logic [LOW_ADDR_W-1:0] ADR_SECOND = 11'h2AA;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] OP_AUTO    = 8'h90;
  localparam logic [7:0] OP_SECURE  = 8'h88;
  localparam logic [7:0] OP_PROGRAM = 8'hA0;
  localparam logic [7:0] OP_RESET   = 8'hF0;
  localparam logic [7:0] OP_LEAVE   = 8'h00;

  typedef enum logic [1:0] {
    MODE_READ = 2'b00,
    MODE_AUTO = 2'b01,
    MODE_SUSP = 2'b10,
    MODE_PROG = 2'b11
  } bank_mode_e;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_KEY1,
    SEQ_KEY2,
    SEQ_PROG,
    SEQ_LEAVE
  } seq_state_e;

  typedef struct packed {
    logic enterAuto;
    logic resetCmd;
    logic enterSec;
    logic exitSec;
    logic startProg;
    logic clearTimeout;
  } seq_strobe_t;

endpackage

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wrEn,
  input  logic [LOW_ADDR_W-1:0] lowAddr,
  input  logic [7:0]            cmdByte,
  input  logic [BANK_W-1:0]     cmdBank,
  input  logic [NUM_BANKS-1:0]  eraseActive,
  input  logic [NUM_BANKS-1:0]  autoselMask,
  input  logic                  secMode,
  input  logic                  progRunning,
  input  logic                  progTimedOut,
  output seq_strobe_t           strobe
);

  seq_state_e state, nextState;
  logic [NUM_BANKS-1:0] bankBit;
  logic anyErase;
  logic autoAllowed;
  logic progAllowed;

  assign bankBit     = NUM_BANKS'(1) << cmdBank;
  assign anyErase    = |eraseActive;
  assign autoAllowed = !anyErase && ((autoselMask & bankBit) == '0);
  assign progAllowed = ((eraseActive | autoselMask) & bankBit) == '0;

  always_comb begin
    strobe    = '0;
    nextState = state;
    if (wrEn) begin
      nextState = SEQ_IDLE;
      if (progRunning && !progTimedOut) begin
        nextState = SEQ_IDLE;
      end else if (progTimedOut) begin
        strobe.clearTimeout = (cmdByte == OP_RESET);
      end else if (cmdByte == OP_RESET && state != SEQ_PROG && state != SEQ_LEAVE) begin
        strobe.resetCmd = 1'b1;
      end else begin
        unique case (state)
          SEQ_IDLE: begin
            if (lowAddr == ADR_FIRST && cmdByte == KEY_FIRST) nextState = SEQ_KEY1;
          end
          SEQ_KEY1: begin
            if (lowAddr == ADR_SECOND && cmdByte == KEY_SECOND) nextState = SEQ_KEY2;
          end
          SEQ_KEY2: begin
            if (lowAddr == ADR_FIRST) begin
              if (cmdByte == OP_AUTO) begin
                if (secMode) nextState = SEQ_LEAVE;
                else strobe.enterAuto = autoAllowed;
              end else if (cmdByte == OP_SECURE) begin
                strobe.enterSec = !anyErase;
              end else if (cmdByte == OP_PROGRAM) begin
                nextState = SEQ_PROG;
              end
            end
          end
          SEQ_PROG: begin
            strobe.startProg = progAllowed;
          end
          SEQ_LEAVE: begin
            strobe.exitSec = (cmdByte == OP_LEAVE);
          end
          default: nextState = SEQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEQ_IDLE;
    else        state <= nextState;
  end

endmodule

// File: rtl/flash_cmd_dp.sv
`timescale 1ns/1ps
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int PROG_LAT  = 8,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CNT_W  = (PROG_LAT > 2) ? $clog2(PROG_LAT) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  seq_strobe_t            strobe,
  input  logic [BANK_W-1:0]      cmdBank,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [NUM_BANKS-1:0]   eraseSuspended,
  input  logic                   verifyFail,
  output logic [NUM_BANKS-1:0]   autoselMask,
  output logic                   secMode,
  output logic                   progRunning,
  output logic                   progTimedOut,
  output logic [2*NUM_BANKS-1:0] bankMode,
  output logic [ADDR_W-1:0]      progAddr,
  output logic [DATA_W-1:0]      progData
);

  logic [CNT_W-1:0]  cnt;
  logic [BANK_W-1:0] progBank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      autoselMask  <= '0;
      secMode      <= 1'b0;
      progRunning  <= 1'b0;
      progTimedOut <= 1'b0;
      cnt          <= '0;
      progBank     <= '0;
      progAddr     <= '0;
      progData     <= '0;
    end else begin
      if (strobe.resetCmd)       autoselMask <= '0;
      else if (strobe.enterAuto) autoselMask[cmdBank] <= 1'b1;

      if (strobe.enterSec)     secMode <= 1'b1;
      else if (strobe.exitSec) secMode <= 1'b0;

      if (strobe.startProg) begin
        progRunning  <= 1'b1;
        progTimedOut <= 1'b0;
        cnt          <= CNT_W'(PROG_LAT - 1);
        progBank     <= cmdBank;
        progAddr     <= addr;
        progData     <= wrData;
      end else if (strobe.clearTimeout) begin
        progRunning  <= 1'b0;
        progTimedOut <= 1'b0;
        progAddr     <= '0;
        progData     <= '0;
      end else if (progRunning && !progTimedOut) begin
        if (cnt == '0) begin
          if (verifyFail) begin
            progTimedOut <= 1'b1;
          end else begin
            progRunning <= 1'b0;
            progAddr    <= '0;
            progData    <= '0;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_mode
    bank_mode_e m;
    always_comb begin
      if (progRunning && progBank == BANK_W'(g)) m = MODE_PROG;
      else if (autoselMask[g])                   m = MODE_AUTO;
      else if (eraseSuspended[g])                m = MODE_SUSP;
      else                                       m = MODE_READ;
    end
    assign bankMode[2*g +: 2] = m;
  end

endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16,
  parameter int PROG_LAT  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [NUM_BANKS-1:0]   eraseActive,
  input  logic [NUM_BANKS-1:0]   eraseSuspended,
  input  logic                   verifyFail,
  output logic [2*NUM_BANKS-1:0] bankMode,
  output logic                   secSel,
  output logic                   ready,
  output logic                   timeoutFlag,
  output logic [ADDR_W-1:0]      progAddr,
  output logic [DATA_W-1:0]      progData
);

  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  seq_strobe_t           strobe;
  logic [BANK_W-1:0]     cmdBank;
  logic [NUM_BANKS-1:0]  autoselMask;
  logic                  secMode;
  logic                  progRunning;
  logic                  progTimedOut;

  assign cmdBank = addr[ADDR_W-1 -: BANK_W];

  flash_cmd_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wrEn         (wrEn),
    .lowAddr      (addr[LOW_ADDR_W-1:0]),
    .cmdByte      (wrData[7:0]),
    .cmdBank      (cmdBank),
    .eraseActive  (eraseActive),
    .autoselMask  (autoselMask),
    .secMode      (secMode),
    .progRunning  (progRunning),
    .progTimedOut (progTimedOut),
    .strobe       (strobe)
  );

  flash_cmd_dp #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PROG_LAT  (PROG_LAT)
  ) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobe         (strobe),
    .cmdBank        (cmdBank),
    .addr           (addr),
    .wrData         (wrData),
    .eraseSuspended (eraseSuspended),
    .verifyFail     (verifyFail),
    .autoselMask    (autoselMask),
    .secMode        (secMode),
    .progRunning    (progRunning),
    .progTimedOut   (progTimedOut),
    .bankMode       (bankMode),
    .progAddr       (progAddr),
    .progData       (progData)
  );

  assign secSel      = secMode;
  assign ready       = !progRunning;
  assign timeoutFlag = progTimedOut;

endmodule

// File: rtl/flash_cmd_chk.sv
`timescale 1ns/1ps
module flash_cmd_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wrEn,
  input logic [DATA_W-1:0]      wrData,
  input logic [2*NUM_BANKS-1:0] bankMode,
  input logic                   secSel,
  input logic                   ready,
  input logic                   timeoutFlag,
  input logic [ADDR_W-1:0]      progAddr
);

  logic [NUM_BANKS-1:0] progMask;
  always_comb begin
    for (int i = 0; i < NUM_BANKS; i++) progMask[i] = (bankMode[2*i +: 2] == 2'b11);
  end

  a_r5_single_prog_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(progMask));

  a_r5_ready_vs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ready == (progMask == '0));

  a_r5_addr_released: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (progAddr == '0));

  a_r5_start_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(wrEn));

  a_r6_busy_keeps_sec: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !timeoutFlag && wrEn) |=> $stable(secSel));

  a_r8_entry_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(secSel) |-> ($past(wrEn) && $past(wrData[7:0]) == 8'h88));

  a_r10_timeout_busy: assert property (@(posedge clk) disable iff (!rst_n)
    timeoutFlag |-> !ready);

endmodule

bind flash_cmd_seq flash_cmd_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wrEn        (wrEn),
  .wrData      (wrData),
  .bankMode    (bankMode),
  .secSel      (secSel),
  .ready       (ready),
  .timeoutFlag (timeoutFlag),
  .progAddr    (progAddr)
);

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;

  localparam int NB  = 4;
  localparam int AW  = 22;
  localparam int DW  = 16;
  localparam int LAT = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [NB-1:0] eraseActive = '0;
  logic [NB-1:0] eraseSuspended = '0;
  logic          verifyFail = 1'b0;
  logic [2*NB-1:0] bankMode;
  logic          secSel;
  logic          ready;
  logic          timeoutFlag;
  logic [AW-1:0] progAddr;
  logic [DW-1:0] progData;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  flash_cmd_seq #(.NUM_BANKS(NB), .ADDR_W(AW), .DATA_W(DW), .PROG_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .eraseActive(eraseActive), .eraseSuspended(eraseSuspended), .verifyFail(verifyFail),
    .bankMode(bankMode), .secSel(secSel), .ready(ready), .timeoutFlag(timeoutFlag),
    .progAddr(progAddr), .progData(progData)
  );

  function automatic logic [AW-1:0] ba(input int bank, input logic [10:0] low);
    return {bank[1:0], 9'h000, low};
  endfunction

  function automatic logic [1:0] modeOf(input int bank);
    return bankMode[2*bank +: 2];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = {8'h00, d};
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wr16(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic unlock();
    wr(ba(0, 11'h555), 8'hAA);
    wr(ba(0, 11'h2AA), 8'h55);
  endtask

  task automatic hwReset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R13 ready", ready, 1);
    check("R13 secSel", secSel, 0);
    check("R13 timeout", timeoutFlag, 0);
    check("R13 modes", bankMode, 0);
    check("R13 progAddr", progAddr, 0);
    check("R13 progData", progData, 0);
  endtask

  task automatic t_autosel();
    unlock();
    wr(ba(1, 11'h555), 8'h90);
    check("R1 R2 bank1 autoselect", bankMode, 8'b00_00_01_00);
    repeat (5) @(negedge clk);
    wr(ba(2, 11'h100), 8'h33);
    check("R2 autoselect persists", modeOf(1), 2'b01);
    wr(ba(3, 11'h000), 8'hF0);
    check("R4 reset to read", bankMode, 0);
  endtask

  task automatic t_autosel_susp();
    eraseSuspended = 4'b0100;
    @(negedge clk);
    check("R4 suspended resting mode", modeOf(2), 2'b10);
    unlock();
    wr(ba(2, 11'h555), 8'h90);
    check("R2 autoselect from suspend", modeOf(2), 2'b01);
    wr(ba(0, 11'h000), 8'hF0);
    check("R4 reset back to suspend-read", modeOf(2), 2'b10);
    eraseSuspended = '0;
    @(negedge clk);
  endtask

  task automatic t_autosel_reject();
    eraseActive = 4'b1000;
    unlock();
    wr(ba(0, 11'h555), 8'h90);
    check("R3 refused while other bank erasing", bankMode, 0);
    eraseActive = '0;
    @(negedge clk);
  endtask

  task automatic t_broken();
    wr(ba(0, 11'h554), 8'hAA);
    wr(ba(0, 11'h2AA), 8'h55);
    wr(ba(0, 11'h555), 8'h90);
    check("R11 bad first address", bankMode, 0);
    wr(ba(0, 11'h555), 8'hAA);
    wr(ba(0, 11'h2AA), 8'h54);
    wr(ba(0, 11'h555), 8'h90);
    check("R11 bad second data", bankMode, 0);
    unlock();
    wr(ba(0, 11'h556), 8'h90);
    check("R11 bad third address", bankMode, 0);
    unlock();
    wr(ba(0, 11'h555), 8'h90);
    check("R11 fresh prefix works", modeOf(0), 2'b01);
    wr(ba(0, 11'h000), 8'hF0);
  endtask

  task automatic t_program();
    unlock();
    wr(ba(0, 11'h555), 8'hA0);
    wr16(ba(2, 11'h123), 16'h5A3C);
    check("R5 ready low", ready, 0);
    check("R5 bank2 programming", modeOf(2), 2'b11);
    check("R5 progAddr", progAddr, ba(2, 11'h123));
    check("R5 progData", progData, 16'h5A3C);
    repeat (LAT-1) @(negedge clk);
    check("R5 still busy at last cycle", ready, 0);
    @(negedge clk);
    check("R5 ready after PROG_LAT", ready, 1);
    check("R5 bank2 back to read", modeOf(2), 2'b00);
    check("R5 address released", progAddr, 0);
  endtask

  task automatic t_prog_ignore();
    int cycles;
    unlock();
    wr(ba(0, 11'h555), 8'hA0);
    wr16(ba(1, 11'h0F0), 16'h00F0);
    cycles = 0;
    unlock();                   cycles += 2;
    wr(ba(0, 11'h555), 8'h88);  cycles += 1;
    wr(ba(0, 11'h000), 8'hF0);  cycles += 1;
    while (!ready && cycles < 100) begin
      @(negedge clk);
      cycles++;
    end
    check("R6 secured entry ignored while busy", secSel, 0);
    check("R6 length unchanged by writes", cycles, LAT);
  endtask

  task automatic t_prog_reject();
    eraseActive = 4'b0001;
    unlock();
    wr(ba(0, 11'h555), 8'hA0);
    wr16(ba(0, 11'h010), 16'h1234);
    check("R12 refused on erasing bank", ready, 1);
    eraseActive = '0;
    unlock();
    wr(ba(1, 11'h555), 8'h90);
    unlock();
    wr(ba(0, 11'h555), 8'hA0);
    wr16(ba(1, 11'h010), 16'h1234);
    check("R12 refused on autoselect bank", ready, 1);
    check("R12 bank1 stays autoselect", modeOf(1), 2'b01);
    wr(ba(0, 11'h000), 8'hF0);
  endtask

  task automatic t_timeout();
    eraseSuspended = 4'b1000;
    verifyFail = 1'b1;
    unlock();
    wr(ba(0, 11'h555), 8'hA0);
    wr16(ba(3, 11'h042), 16'hBEEF);
    repeat (LAT) @(negedge clk);
    check("R10 timeout raised", timeoutFlag, 1);
    check("R10 ready held low", ready, 0);
    check("R10 bank3 stays programming", modeOf(3), 2'b11);
    verifyFail = 1'b0;
    wr(ba(0, 11'h555), 8'hAA);
    check("R10 non-reset write ignored", timeoutFlag, 1);
    wr(ba(0, 11'h000), 8'hF0);
    check("R10 reset clears timeout", timeoutFlag, 0);
    check("R10 ready restored", ready, 1);
    check("R10 bank3 to suspend-read", modeOf(3), 2'b10);
    eraseSuspended = '0;
    @(negedge clk);
  endtask

  task automatic t_hwreset();
    unlock();
    wr(ba(0, 11'h555), 8'hA0);
    wr16(ba(2, 11'h200), 16'h7777);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R7 ready during reset", ready, 1);
    check("R7 modes cleared", bankMode, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_secured();
    eraseActive = 4'b0010;
    unlock();
    wr(ba(0, 11'h555), 8'h88);
    check("R8 entry refused while erasing", secSel, 0);
    eraseActive = '0;
    unlock();
    wr(ba(0, 11'h555), 8'h88);
    check("R8 entry sets secSel", secSel, 1);
    unlock();
    wr(ba(1, 11'h555), 8'h90);
    check("R9 no autoselect while secured", bankMode, 0);
    wr(ba(0, 11'h000), 8'h12);
    check("R9 wrong final data keeps secSel", secSel, 1);
    unlock();
    wr(ba(0, 11'h555), 8'h90);
    wr(ba(0, 11'h000), 8'h00);
    check("R9 exit clears secSel", secSel, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_autosel();
    t_autosel_susp();
    t_autosel_reject();
    t_broken();
    t_program();
    t_prog_ignore();
    t_prog_reject();
    t_timeout();
    t_hwreset();
    t_secured();
    hwReset();
    t_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule